// File: doc/BRIEF.md
# Disk Bus-Master DMA Channel

This block is the data mover for one disk channel. Software loads the memory address of a descriptor table, sets a transfer direction and then sets a run bit, normally after it has already sent the disk its command. The engine then reads the table one 8-byte entry at a time. For each entry it moves the described region a dword at a time, either from a device-side receive stream into memory or from memory out to a device-side transmit stream. After the entry flagged as last has been moved, it drops its active flag.

Completion is reported through a status byte. A rising edge on the device interrupt input sets an interrupt flag. The engine raises an error flag in two cases: the device signals its end while table entries are still pending, or the device offers more read data after the table is used up. A healthy transfer leaves the low three status bits at interrupt-set, not-active, no-error. The two flags are cleared by writing ones to them. Two capability bits are plain storage for software. A read-only bit, fixed by a parameter, tells software whether only one channel may run DMA at a time.

Top module: `disk_dma_channel`

## Requirements
- R1: After reset the command register reads 0, the status register reads only the simplex bit (bit 7, value of the SIMPLEX parameter), the table pointer reads 0, and no memory request, receive-ready or transmit-valid is asserted.
- R2: The command register is at offset 0. Bit 0 is run and bit 3 is direction (1 = device to memory), and it reads back as written in those two bits. A change of bit 3 written while the engine is active is ignored.
- R3: The table is a list of 8-byte entries fetched in order from the pointer. The word at +0 is the region address (its low 2 bits are ignored). The word at +4 holds a byte count in bits 15:0, a multiple of 4, where 0 means 65536 bytes. Bit 31 of that word marks the last entry.
- R4: In device-to-memory mode each word taken from the receive stream is written to the next dword address of the current region, in stream order.
- R5: In memory-to-device mode each dword of the current region is read from memory and sent on the transmit stream, in address order.
- R6: Status bit 0 (active) is set by a run-bit 0-to-1 write and cleared once the last entry's data has moved. A normal transfer followed by a device interrupt reads status bits 2:0 as 3'b100.
- R7: Status bit 2 is set by a rising edge on the device interrupt. Writing 1 to status bit 2 clears it, and writing 0 leaves it unchanged.
- R8: A device interrupt edge while active sets status bits 1 and 2 together and stops the engine. Writing 1 to bit 1 clears it.
- R9: In device-to-memory mode, receive data offered after the last entry has completed, before the next device interrupt, sets status bit 1.
- R10: Writing run = 0 while active stops the engine at once, clears active, and does not set the error bit. No further memory or transmit traffic follows.
- R11: Status bits 5 and 6 are software read/write. Bit 7 ignores writes. Bits 4:3 read 0.
- R12: The table pointer register is at offset 4. Its low 2 bits read as 0.
- R13: While not active, receive-ready, transmit-valid and memory request stay low. Receive data offered before run is set is kept and transferred after start.
- R14: A memory request holds its address, write flag and write data unchanged until it is acknowledged, unless a stop or an abort intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset (0 command, 2 status, 4 table pointer) |
| host_wdata | input | 32 | Register write data (byte registers use bits 7:0) |
| host_rdata | output | 32 | Register read data for host_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory dword address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| dev_rx_valid | input | 1 | Device offers a data word |
| dev_rx_data | input | 32 | Device data word |
| dev_rx_ready | output | 1 | Engine takes the offered word |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_data | output | 32 | Word to the device |
| dev_tx_ready | input | 1 | Device takes the offered word |
| dev_irq | input | 1 | Device interrupt (edge sensitive) |

## Verification
The request-holding property assumes the memory side raises mem_ack only while a request is up. It also assumes no stop write and no device interrupt edge arrives while a memory request waits for acknowledgement, because both of those withdraw the request. The bench's memory model acks only pending requests, sometimes after a stall. Stops and device interrupts are issued only while the engine waits on a device stream, so the tolerated withdrawal never meets an outstanding memory access. All register writes are single-cycle strobes, and every stream word is offered stably until taken.

// File: rtl/disk_dma_pkg.sv
// Shared constants and types for the disk DMA channel.
// Assumes 32-bit dword data and byte-granular 32-bit memory addresses.
package disk_dma_pkg;
    localparam int WORD_W = 32;

    localparam logic [2:0] OFS_CMD   = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd2;
    localparam logic [2:0] OFS_TABLE = 3'd4;

    localparam int CMD_RUN   = 0;
    localparam int CMD_TOMEM = 3;

    localparam int ST_BUSY   = 0;
    localparam int ST_FAULT  = 1;
    localparam int ST_IRQ    = 2;
    localparam int ST_CAP0   = 5;
    localparam int ST_CAP1   = 6;
    localparam int ST_SOLO   = 7;

    localparam int ENTRY_END = 31;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_GET_ADDR,
        ENG_GET_LEN,
        ENG_MOVE
    } eng_state_t;
endpackage

// File: rtl/disk_dma_regs.sv
// Host register file of the DMA channel: command, status and table pointer.
// Assumes single-cycle write strobes; reads are combinational on host_addr.
// Produces launch/halt pulses and the interrupt edge for the engine.
module disk_dma_regs
    import disk_dma_pkg::*;
#(
    parameter bit SIMPLEX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              dev_irq,
    input  logic              active,
    input  logic              err_set,
    output logic              launch,
    output logic              halt,
    output logic              to_mem,
    output logic [WORD_W-1:0] table_base,
    output logic              irq_rise
);
    logic              run_q;
    logic              dir_q;
    logic [1:0]        cap_q;
    logic              fault_q;
    logic              irq_flag_q;
    logic              irq_prev_q;
    logic [WORD_W-3:0] base_q;
    logic              wr_cmd, wr_stat, wr_table;

    // Decode which register a write targets.
    always_comb begin
        wr_cmd   = host_wr && (host_addr == OFS_CMD);
        wr_stat  = host_wr && (host_addr == OFS_STAT);
        wr_table = host_wr && (host_addr == OFS_TABLE);
    end

    // Run-bit transitions become one-cycle engine commands.
    always_comb begin
        launch   = wr_cmd &&  host_wdata[CMD_RUN] && !run_q;
        halt     = wr_cmd && !host_wdata[CMD_RUN] &&  run_q;
        irq_rise = dev_irq && !irq_prev_q;
    end

    // Command register; direction is frozen while the engine runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            dir_q <= 1'b0;
        end else if (wr_cmd) begin
            run_q <= host_wdata[CMD_RUN];
            if (!active) dir_q <= host_wdata[CMD_TOMEM];
        end
    end

    // Status flags: set events win over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= '0;
            fault_q    <= 1'b0;
            irq_flag_q <= 1'b0;
            irq_prev_q <= 1'b0;
        end else begin
            irq_prev_q <= dev_irq;
            if (wr_stat) cap_q <= {host_wdata[ST_CAP1], host_wdata[ST_CAP0]};
            if (err_set)                            fault_q <= 1'b1;
            else if (wr_stat && host_wdata[ST_FAULT]) fault_q <= 1'b0;
            if (irq_rise)                           irq_flag_q <= 1'b1;
            else if (wr_stat && host_wdata[ST_IRQ]) irq_flag_q <= 1'b0;
        end
    end

    // Descriptor table pointer, dword aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (wr_table) base_q <= host_wdata[WORD_W-1:2];
    end

    // Read multiplexer and engine-facing outputs.
    always_comb begin
        to_mem     = dir_q;
        table_base = {base_q, 2'b00};
        host_rdata = '0;
        case (host_addr)
            OFS_CMD: begin
                host_rdata[CMD_RUN]   = run_q;
                host_rdata[CMD_TOMEM] = dir_q;
            end
            OFS_STAT: begin
                host_rdata[ST_BUSY]  = active;
                host_rdata[ST_FAULT] = fault_q;
                host_rdata[ST_IRQ]   = irq_flag_q;
                host_rdata[ST_CAP0]  = cap_q[0];
                host_rdata[ST_CAP1]  = cap_q[1];
                host_rdata[ST_SOLO]  = SIMPLEX;
            end
            OFS_TABLE: host_rdata = {base_q, 2'b00};
            default:   host_rdata = '0;
        endcase
    end

    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |=> irq_flag_q); // R7
    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && host_wdata[ST_FAULT] && !err_set) |=> !fault_q); // R8
    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(dir_q)); // R2
endmodule

// File: rtl/disk_dma_engine.sv
// Descriptor walker and word mover of the DMA channel.
// Assumes dword-multiple region lengths; one word is buffered at a time.
// Withdraws any pending memory request on halt or device-end abort.
module disk_dma_engine
    import disk_dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              halt,
    input  logic              to_mem,
    input  logic [WORD_W-1:0] table_base,
    input  logic              irq_rise,
    output logic              active,
    output logic              err_set,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              dev_rx_valid,
    input  logic [WORD_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [WORD_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready
);
    localparam int WORDS_W = LEN_W - 1;
    localparam logic [WORDS_W-1:0] FULL_WORDS = WORDS_W'(1) << (LEN_W - 2);

    eng_state_t        state;
    logic [WORD_W-1:0] entry_ptr;
    logic [WORD_W-1:0] region_ptr;
    logic [WORD_W-1:0] hold;
    logic              hold_full;
    logic [WORDS_W-1:0] words_left;
    logic              final_entry;
    logic              tail_watch;
    logic              moving, beat_done, abort;

    // Bus and stream handshakes derived from state and the holding word.
    always_comb begin
        moving       = (state == ENG_MOVE);
        active       = (state != ENG_IDLE);
        mem_req      = (state == ENG_GET_ADDR) || (state == ENG_GET_LEN) ||
                       (moving && (to_mem ? hold_full : !hold_full));
        mem_we       = moving && to_mem;
        mem_addr     = moving ? region_ptr : entry_ptr;
        mem_wdata    = hold;
        dev_rx_ready = moving && to_mem && !hold_full;
        dev_tx_valid = moving && !to_mem && hold_full;
        dev_tx_data  = hold;
        beat_done    = moving && hold_full && (to_mem ? mem_ack : dev_tx_ready);
        abort        = halt || (irq_rise && active);
        err_set      = (irq_rise && active) ||
                       (!active && tail_watch && dev_rx_valid && !irq_rise && !launch);
    end

    // Sequencer: fetch entry address, fetch length, move words, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ENG_IDLE;
            entry_ptr   <= '0;
            region_ptr  <= '0;
            hold        <= '0;
            hold_full   <= 1'b0;
            words_left  <= '0;
            final_entry <= 1'b0;
            tail_watch  <= 1'b0;
        end else if (abort) begin
            state      <= ENG_IDLE;
            hold_full  <= 1'b0;
            tail_watch <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (launch) begin
                        state      <= ENG_GET_ADDR;
                        entry_ptr  <= table_base;
                        tail_watch <= 1'b0;
                    end else if (irq_rise || dev_rx_valid) begin
                        tail_watch <= 1'b0;
                    end
                end
                ENG_GET_ADDR: begin
                    if (mem_ack) begin
                        region_ptr <= {mem_rdata[WORD_W-1:2], 2'b00};
                        entry_ptr  <= entry_ptr + 32'd4;
                        state      <= ENG_GET_LEN;
                    end
                end
                ENG_GET_LEN: begin
                    if (mem_ack) begin
                        words_left  <= (mem_rdata[LEN_W-1:2] == '0) ? FULL_WORDS
                                       : WORDS_W'(mem_rdata[LEN_W-1:2]);
                        final_entry <= mem_rdata[ENTRY_END];
                        entry_ptr   <= entry_ptr + 32'd4;
                        hold_full   <= 1'b0;
                        state       <= ENG_MOVE;
                    end
                end
                ENG_MOVE: begin
                    if (!hold_full) begin
                        if (to_mem && dev_rx_valid) begin
                            hold      <= dev_rx_data;
                            hold_full <= 1'b1;
                        end else if (!to_mem && mem_ack) begin
                            hold      <= mem_rdata;
                            hold_full <= 1'b1;
                        end
                    end else if (beat_done) begin
                        hold_full  <= 1'b0;
                        region_ptr <= region_ptr + 32'd4;
                        words_left <= words_left - WORDS_W'(1);
                        if (words_left == WORDS_W'(1)) begin
                            if (final_entry) begin
                                state      <= ENG_IDLE;
                                tail_watch <= to_mem;
                            end else begin
                                state <= ENG_GET_ADDR;
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !halt && !irq_rise) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R14
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!mem_req && !dev_rx_ready && !dev_tx_valid)); // R13
    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !active); // R10
    AST_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rise && active) |=> !active); // R8
endmodule

// File: rtl/disk_dma_channel.sv
// Top of one bus-master disk DMA channel: register file plus engine.
// Assumes a memory port that acknowledges only pending requests.
module disk_dma_channel
    import disk_dma_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter bit SIMPLEX = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        dev_rx_valid,
    input  logic [31:0] dev_rx_data,
    output logic        dev_rx_ready,
    output logic        dev_tx_valid,
    output logic [31:0] dev_tx_data,
    input  logic        dev_tx_ready,
    input  logic        dev_irq
);
    logic              launch, halt, to_mem, irq_rise, active, err_set;
    logic [WORD_W-1:0] table_base;

    disk_dma_regs #(.SIMPLEX(SIMPLEX)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_irq(dev_irq),
        .active(active), .err_set(err_set), .launch(launch), .halt(halt),
        .to_mem(to_mem), .table_base(table_base), .irq_rise(irq_rise)
    );

    disk_dma_engine #(.LEN_W(LEN_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .launch(launch), .halt(halt), .to_mem(to_mem),
        .table_base(table_base), .irq_rise(irq_rise), .active(active),
        .err_set(err_set), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready)
    );
endmodule

// File: tb/sim_disk_dma_channel.sv
module sim_disk_dma_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dev_rx_valid = 1'b0;
    logic [31:0] dev_rx_data = '0;
    logic        dev_rx_ready;
    logic        dev_tx_valid;
    logic [31:0] dev_tx_data;
    logic        dev_tx_ready = 1'b0;
    logic        dev_irq = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rx_q[$];
    logic [63:0] exp_wr[$];
    logic [31:0] exp_tx[$];
    bit rx_en = 1'b0;
    bit rx_pend = 1'b0;
    bit tx_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disk_dma_channel u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready), .dev_irq(dev_irq)
    );

    function automatic logic [31:0] rdmem(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural memory, receive source and transmit sink, updated every clock.
    initial begin
        logic [63:0] e;
        logic [31:0] junk;
        forever begin
            @(negedge clk);
            cyc++;
            if (rx_pend) begin junk = rx_q.pop_front(); rx_pend = 1'b0; end
            mem_ack = 1'b0;
            if (mem_req && (cyc % 3 != 0)) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    if (exp_wr.size() == 0) chk("R4 unexpected memory write", mem_addr, 32'hFFFF_FFFF);
                    else begin
                        e = exp_wr.pop_front();
                        chk("R4 write address", mem_addr, e[63:32]);
                        chk("R4 write data", mem_wdata, e[31:0]);
                    end
                end else begin
                    mem_rdata = rdmem(mem_addr);
                end
            end
            dev_rx_valid = rx_en && (rx_q.size() > 0);
            dev_rx_data  = (rx_q.size() > 0) ? rx_q[0] : 32'h0;
            rx_pend      = dev_rx_valid && dev_rx_ready;
            dev_tx_ready = tx_en;
            if (dev_tx_valid && tx_en) begin
                if (exp_tx.size() == 0) chk("R5 unexpected transmit word", dev_tx_data, 32'hFFFF_FFFF);
                else chk("R5 transmit word", dev_tx_data, exp_tx.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        host_addr = a;
        #1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic wait_idle(input int limit);
        host_addr = 3'd2;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            #1;
            if (!host_rdata[0]) return;
        end
        chk("R6 engine never went idle", 32'h1, 32'h0);
    endtask

    task automatic irq_pulse();
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        miscompares++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 command after reset", 3'd0, 32'h0);
        rd("R1 status after reset", 3'd2, 32'h0);
        rd("R1 pointer after reset", 3'd4, 32'h0);
        chk("R1 idle outputs", {29'd0, mem_req, dev_rx_ready, dev_tx_valid}, 32'h0);

        // R11 capability and simplex bits
        wr(3'd2, 32'hF8);
        rd("R11 caps set, simplex and low bits unwritable", 3'd2, 32'h60);
        wr(3'd2, 32'h00);
        rd("R11 caps cleared", 3'd2, 32'h0);

        // R12 pointer alignment
        wr(3'd4, 32'h0000_1003);
        rd("R12 pointer low bits read zero", 3'd4, 32'h0000_1000);

        // R3/R4/R13 device-to-memory, two entries, data offered before start
        mem[32'h1000] = 32'h2000;      mem[32'h1004] = 32'h0000_000C;
        mem[32'h1008] = 32'h3002;      mem[32'h100C] = 32'h8000_0008;
        for (int i = 0; i < 5; i++) rx_q.push_back(32'hD000_0000 + i);
        exp_wr.push_back({32'h2000, 32'hD000_0000});
        exp_wr.push_back({32'h2004, 32'hD000_0001});
        exp_wr.push_back({32'h2008, 32'hD000_0002});
        exp_wr.push_back({32'h3000, 32'hD000_0003});
        exp_wr.push_back({32'h3004, 32'hD000_0004});
        rx_en = 1'b1;
        wr(3'd0, 32'h08);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R13 receive-ready low before start", {31'd0, dev_rx_ready}, 32'h0);
        end
        wr(3'd0, 32'h09);
        rd("R6 active after start", 3'd2, 32'h01);
        wr(3'd0, 32'h01);
        rd("R2 direction frozen while active", 3'd0, 32'h09);
        wait_idle(2000);
        rd("R6 idle, no error after table", 3'd2, 32'h00);
        chk("R4 all words written (R13 none lost)", exp_wr.size(), 32'd0);
        irq_pulse();
        rd("R6 good completion pattern", 3'd2, 32'h04);
        wr(3'd2, 32'h00);
        rd("R7 writing zero keeps interrupt", 3'd2, 32'h04);
        wr(3'd2, 32'h02);
        rd("R7 writing other bit keeps interrupt", 3'd2, 32'h04);
        wr(3'd2, 32'h04);
        rd("R7 write one clears interrupt", 3'd2, 32'h00);

        // R5 memory-to-device with a stalled sink at first
        wr(3'd0, 32'h00);
        rd("R2 direction change accepted when idle", 3'd0, 32'h00);
        mem[32'h1100] = 32'h4000;      mem[32'h1104] = 32'h8000_0010;
        for (int i = 0; i < 4; i++) exp_tx.push_back(rdmem(32'h4000 + 4*i));
        wr(3'd4, 32'h1100);
        tx_en = 1'b0;
        wr(3'd0, 32'h01);
        repeat (6) @(negedge clk);
        tx_en = 1'b1;
        wait_idle(2000);
        chk("R5 all words sent", exp_tx.size(), 32'd0);
        irq_pulse();
        rd("R6 good completion after transmit", 3'd2, 32'h04);
        wr(3'd2, 32'h04);

        // R8 device ends early
        wr(3'd0, 32'h08);
        mem[32'h1200] = 32'h5000;      mem[32'h1204] = 32'h8000_0040;
        rx_q.push_back(32'hE000_0000); rx_q.push_back(32'hE000_0001);
        exp_wr.push_back({32'h5000, 32'hE000_0000});
        exp_wr.push_back({32'h5004, 32'hE000_0001});
        wr(3'd4, 32'h1200);
        wr(3'd0, 32'h09);
        for (int i = 0; i < 2000 && exp_wr.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        rd("R8 still active before device end", 3'd2, 32'h01);
        irq_pulse();
        rd("R8 early end sets error and interrupt", 3'd2, 32'h06);
        chk("R8 receive-ready low after abort", {31'd0, dev_rx_ready}, 32'h0);
        wr(3'd2, 32'h06);
        rd("R8 flags cleared by writing ones", 3'd2, 32'h00);
        wr(3'd0, 32'h08);

        // R9 device offers data past the end of the table
        mem[32'h1300] = 32'h6000;      mem[32'h1304] = 32'h8000_0008;
        for (int i = 0; i < 3; i++) rx_q.push_back(32'hF000_0000 + i);
        exp_wr.push_back({32'h6000, 32'hF000_0000});
        exp_wr.push_back({32'h6004, 32'hF000_0001});
        wr(3'd4, 32'h1300);
        wr(3'd0, 32'h09);
        wait_idle(2000);
        repeat (2) @(negedge clk);
        rd("R9 overrun sets error", 3'd2, 32'h02);
        rx_en = 1'b0;
        rx_q.delete();
        irq_pulse();
        rd("R9 error kept, interrupt added", 3'd2, 32'h06);
        wr(3'd2, 32'h06);
        wr(3'd0, 32'h00);

        // R10 stop while active
        mem[32'h1400] = 32'h7000;      mem[32'h1404] = 32'h8000_0040;
        wr(3'd4, 32'h1400);
        tx_en = 1'b0;
        wr(3'd0, 32'h01);
        repeat (10) @(negedge clk);
        rd("R10 active before stop", 3'd2, 32'h01);
        wr(3'd0, 32'h00);
        rd("R10 stop clears active without error", 3'd2, 32'h00);
        tx_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R10 no traffic after stop", {30'd0, mem_req, dev_tx_valid}, 32'h0);
        end

        // R3 zero length field means 65536 bytes
        mem[32'h1500] = 32'h0010_0000; mem[32'h1504] = 32'h8000_0000;
        for (int i = 0; i < 16384; i++) exp_tx.push_back(rdmem(32'h0010_0000 + 4*i));
        wr(3'd4, 32'h1500);
        wr(3'd0, 32'h01);
        wait_idle(150000);
        chk("R3 full-size region sent", exp_tx.size(), 32'd0);
        rd("R6 idle after full-size region", 3'd2, 32'h00);

        finish_run();
    end
endmodule